// File: doc/BRIEF.md
# Serial Command and Response Slave

This block is the slave end of a four-wire serial link. It puts 8-byte command blocks into a command buffer and sends 16-byte response blocks back out. An active-low enable marks each frame. The first eight bits of every frame form a control byte. The control byte decides whether the host writes a command or reads a response. For a read, it also decides which output pin carries the data.

A write frame shifts in 64 argument bits. If the frame completes, the bits move into a held command register, and a one-cycle strobe tells a downstream command processor that a new command is ready. A read frame copies a parallel response word into a shadow register when the control byte completes. The block then sends that word out on either the shared bidirectional data pin or a dedicated output pin. When the shared pin is used, a half-cycle turnaround comes first.

All serial inputs pass through synchronizers into the system clock domain. Edges of the serial clock are detected there, so the serial clock must be slow compared with the system clock. The meaning of individual commands is outside this block.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, `sdio_oe_o`, `gpo_oe_o`, `cmd_valid_o` and `cmd_data_o` are all zero.
- R2: While `sen_ni` is low, the first 8 bits sampled on rising edges of `sclk_i` form the control byte, most significant bit first. Value 0x48 selects a write, 0x80 selects a read on the shared pin, and 0xC0 selects a read on the dedicated pin.
- R3: A write takes 64 bits after the control byte, most significant bit first. The first byte lands in `cmd_data_o[63:56]`. When the 64th bit is sampled, `cmd_data_o` updates and `cmd_valid_o` pulses for exactly one clock. Any further bits in the same frame raise no second pulse.
- R4: If `sen_ni` rises before a write's 64th data bit, no pulse is raised and `cmd_data_o` keeps its previous value.
- R5: Any other control value makes the slave ignore the rest of the frame. No pulse is raised, neither output enable rises, and `cmd_data_o` is unchanged.
- R6: A read sends 128 bits starting from `rsp_data_i[127]` and working downward, one new bit after each falling edge of `sclk_i`. The first bit appears on the falling edge that follows the last rising edge of the control byte. Neither output enable is high while the control byte is being received.
- R7: During a read on the shared pin, `sdio_oe_o` is high and `sdio_o` carries the data, while `gpo_oe_o` stays low.
- R8: During a read on the dedicated pin, `gpo_oe_o` is high and `gpo_o` carries the data, while `sdio_oe_o` stays low for the whole frame.
- R9: `rsp_data_i` is captured when the control byte completes. Changes to it later in the frame do not alter the bits sent.
- R10: The falling edge after the 128th bit releases the output enable. A rising `sen_ni` releases both enables within four system clocks of the synchronized enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sen_ni | input | 1 | Frame enable, active low |
| sdio_i | input | 1 | Shared data pin, input side |
| sdio_o | output | 1 | Shared data pin, output value |
| sdio_oe_o | output | 1 | Shared data pin output enable |
| gpo_o | output | 1 | Dedicated read-data output |
| gpo_oe_o | output | 1 | Dedicated output enable |
| rsp_data_i | input | 128 | Response block, first byte in bits 127:120 |
| cmd_data_o | output | 64 | Last completed command block, first byte in bits 63:56 |
| cmd_valid_o | output | 1 | One-clock strobe when a command block completes |

## Verification
Write frames are sent with a counting pattern, all ones and alternating bits. A byte-order or bit-order slip shows up as a wrong value in the scoreboard rather than a lucky match.

Read frames are run on both pins with asymmetric response words. One read changes the parallel response part way through, which separates a design that latches the response from one that samples it live. Short writes, an unknown control byte, over-long writes and a read cut off by the enable confirm that only complete, recognised frames change the command register or drive a pin.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic [1:0] {
    FS_CTRL,
    FS_WR,
    FS_RD,
    FS_SKIP
  } frame_st_e;

  localparam logic [7:0] CTL_WRITE       = 8'h48;
  localparam logic [7:0] CTL_READ_SHARED = 8'h80;
  localparam logic [7:0] CTL_READ_GPO    = 8'hC0;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int unsigned       W       = 1,
  parameter int unsigned       STAGES  = 2,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe <= '{default: RST_VAL};
    end else begin
      pipe[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/spi_cmd_frame.sv
module spi_cmd_frame
  import spi_cmd_pkg::*;
#(
  parameter int unsigned CMD_BITS = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sen_n_i,
  input  logic                rise_i,
  input  logic                sdi_i,
  output logic                rd_active_o,
  output logic                load_rsp_o,
  output logic                sel_gpo_o,
  output logic [CMD_BITS-1:0] cmd_data_o,
  output logic                cmd_valid_o
);
  localparam int unsigned CNT_W = $clog2(CMD_BITS > 8 ? CMD_BITS : 8);

  frame_st_e           st_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [6:0]          ctl_sr_q;
  logic [CMD_BITS-1:0] cmd_sr_q;
  logic [7:0]          ctl_byte;
  logic [CMD_BITS-1:0] cmd_next;

  assign ctl_byte = {ctl_sr_q, sdi_i};
  assign cmd_next = {cmd_sr_q[CMD_BITS-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= FS_CTRL;
      cnt_q       <= '0;
      ctl_sr_q    <= '0;
      cmd_sr_q    <= '0;
      cmd_data_o  <= '0;
      cmd_valid_o <= 1'b0;
      load_rsp_o  <= 1'b0;
      sel_gpo_o   <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      load_rsp_o  <= 1'b0;
      if (sen_n_i) begin
        st_q  <= FS_CTRL;
        cnt_q <= '0;
      end else begin
        unique case (st_q)
          FS_CTRL: if (rise_i) begin
            ctl_sr_q <= ctl_byte[6:0];
            cnt_q    <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(7)) begin
              cnt_q <= '0;
              case (ctl_byte)
                CTL_WRITE: st_q <= FS_WR;
                CTL_READ_SHARED: begin
                  st_q       <= FS_RD;
                  load_rsp_o <= 1'b1;
                  sel_gpo_o  <= 1'b0;
                end
                CTL_READ_GPO: begin
                  st_q       <= FS_RD;
                  load_rsp_o <= 1'b1;
                  sel_gpo_o  <= 1'b1;
                end
                default: st_q <= FS_SKIP;
              endcase
            end
          end
          FS_WR: if (rise_i) begin
            cmd_sr_q <= cmd_next;
            cnt_q    <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(CMD_BITS - 1)) begin
              cmd_data_o  <= cmd_next;
              cmd_valid_o <= 1'b1;
              st_q        <= FS_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_active_o = (st_q == FS_RD);
endmodule

// File: rtl/spi_cmd_tx.sv
module spi_cmd_tx #(
  parameter int unsigned RSP_BITS = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [RSP_BITS-1:0] rsp_i,
  input  logic                active_i,
  input  logic                fall_i,
  input  logic                sel_gpo_i,
  output logic                sdio_o,
  output logic                sdio_oe_o,
  output logic                gpo_o,
  output logic                gpo_oe_o
);
  localparam int unsigned CNT_W = $clog2(RSP_BITS + 1);

  logic [RSP_BITS-1:0] shadow_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                bit_q;
  logic                drive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      cnt_q    <= '0;
      bit_q    <= 1'b0;
      drive_q  <= 1'b0;
    end else if (load_i) begin
      shadow_q <= rsp_i;
      cnt_q    <= '0;
      drive_q  <= 1'b0;
    end else if (!active_i) begin
      drive_q <= 1'b0;
    end else if (fall_i) begin
      if (cnt_q != CNT_W'(RSP_BITS)) begin
        bit_q    <= shadow_q[RSP_BITS-1];
        shadow_q <= {shadow_q[RSP_BITS-2:0], 1'b0};
        cnt_q    <= cnt_q + 1'b1;
        drive_q  <= 1'b1;
      end else begin
        drive_q <= 1'b0;
      end
    end
  end

  assign sdio_o    = bit_q & ~sel_gpo_i;
  assign gpo_o     = bit_q & sel_gpo_i;
  assign sdio_oe_o = drive_q & ~sel_gpo_i;
  assign gpo_oe_o  = drive_q & sel_gpo_i;
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int unsigned CMD_BYTES   = 8,
  parameter int unsigned RSP_BYTES   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   sen_ni,
  input  logic                   sdio_i,
  output logic                   sdio_o,
  output logic                   sdio_oe_o,
  output logic                   gpo_o,
  output logic                   gpo_oe_o,
  input  logic [RSP_BYTES*8-1:0] rsp_data_i,
  output logic [CMD_BYTES*8-1:0] cmd_data_o,
  output logic                   cmd_valid_o
);
  localparam int unsigned CMD_BITS = CMD_BYTES * 8;
  localparam int unsigned RSP_BITS = RSP_BYTES * 8;

  logic sen_s, sclk_s, sdi_s, sclk_d;
  logic rise, fall;
  logic rd_active, load_rsp, sel_gpo;

  // enable idles high, clock and data low
  spi_cmd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sen_ni, sclk_i, sdio_i}),
    .q_o   ({sen_s, sclk_s, sdi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s;
  end

  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;

  spi_cmd_frame #(.CMD_BITS(CMD_BITS)) i_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sen_n_i    (sen_s),
    .rise_i     (rise),
    .sdi_i      (sdi_s),
    .rd_active_o(rd_active),
    .load_rsp_o (load_rsp),
    .sel_gpo_o  (sel_gpo),
    .cmd_data_o (cmd_data_o),
    .cmd_valid_o(cmd_valid_o)
  );

  spi_cmd_tx #(.RSP_BITS(RSP_BITS)) i_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_rsp),
    .rsp_i    (rsp_data_i),
    .active_i (rd_active),
    .fall_i   (fall),
    .sel_gpo_i(sel_gpo),
    .sdio_o   (sdio_o),
    .sdio_oe_o(sdio_oe_o),
    .gpo_o    (gpo_o),
    .gpo_oe_o (gpo_oe_o)
  );
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk #(
  parameter int unsigned CMD_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sen_ni,
  input logic             sdio_oe_o,
  input logic             gpo_oe_o,
  input logic             cmd_valid_o,
  input logic [CMD_W-1:0] cmd_data_o
);
  // R3
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  // R4
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_data_o) |-> cmd_valid_o);

  // R8
  oe_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sdio_oe_o && gpo_oe_o));

  // R6
  oe_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sdio_oe_o) || $rose(gpo_oe_o)) |-> !sen_ni);

  // R10
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sen_ni && $past(sen_ni) && $past(sen_ni, 2) && $past(sen_ni, 3) && $past(sen_ni, 4))
      |-> (!sdio_oe_o && !gpo_oe_o));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(.CMD_W(CMD_BYTES * 8)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sen_ni     (sen_ni),
  .sdio_oe_o  (sdio_oe_o),
  .gpo_oe_o   (gpo_oe_o),
  .cmd_valid_o(cmd_valid_o),
  .cmd_data_o (cmd_data_o)
);

// File: tb/test_spi_cmd_slave.sv
module test_spi_cmd_slave;
  localparam int H = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sclk = 1'b0, sen_n = 1'b1, sdi = 1'b0;
  logic         sdio_o, sdio_oe, gpo_o, gpo_oe, cmd_valid;
  logic [127:0] rsp_data = '0;
  logic [63:0]  cmd_data;

  int           checks = 0, failures = 0, pulses = 0;
  bit           finished = 1'b0;
  logic [63:0]  exp_q[$];
  logic [63:0]  last_cmd = '0;

  always #10 clk = ~clk;

  spi_cmd_slave i_spi_cmd_slave (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sen_ni(sen_n), .sdio_i(sdi),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe), .gpo_o(gpo_o), .gpo_oe_o(gpo_oe),
    .rsp_data_i(rsp_data), .cmd_data_o(cmd_data), .cmd_valid_o(cmd_valid)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for command strobes (R3, R4, R5)
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      pulses++;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R4/R5 unexpected strobe actual=%0h expected=none", cmd_data);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        if (cmd_data !== e) begin
          failures++;
          $display("FAIL R3 actual=%0h expected=%0h", cmd_data, e);
        end
        last_cmd = e;
      end
    end
  end

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b);
    sclk = 1'b0; sdi = b; half();
    sclk = 1'b1; half();
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
  endtask

  task automatic frame_start();
    sen_n = 1'b0; half();
  endtask

  task automatic frame_stop();
    sclk = 1'b0; half();
    sen_n = 1'b1; half(); half();
  endtask

  task automatic do_write(input logic [63:0] d, input int extra);
    exp_q.push_back(d);
    frame_start();
    send_byte(8'h48);
    for (int i = 63; i >= 0; i--) clk_bit(d[i]);
    for (int i = 0; i < extra; i++) clk_bit(i[0]);
    frame_stop();
  endtask

  task automatic do_read(input bit use_gpo, input logic [127:0] rsp, input bit change_mid);
    string req;
    rsp_data = rsp;
    frame_start();
    send_byte(use_gpo ? 8'hC0 : 8'h80);
    check("R6 turnaround", {126'b0, sdio_oe, gpo_oe}, 128'd0);
    for (int j = 0; j < 128; j++) begin
      sclk = 1'b0; sdi = 1'b0; half();
      req = change_mid ? "R9" : "R6";
      check(req, use_gpo ? gpo_o : sdio_o, rsp[127-j]);
      check(use_gpo ? "R8" : "R7", {126'b0, sdio_oe, gpo_oe},
            use_gpo ? 128'd1 : 128'd2);
      if (change_mid && j == 3) rsp_data = ~rsp;
      sclk = 1'b1; half();
    end
    sclk = 1'b0; half();
    check("R10 end", {126'b0, sdio_oe, gpo_oe}, 128'd0);
    frame_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check("R1", {sdio_oe, gpo_oe, cmd_valid}, 128'd0);
    check("R1", cmd_data, 128'd0);

    // R2 R3: distinct patterns
    do_write(64'h0123_4567_89AB_CDEF, 0);
    do_write(64'hFFFF_FFFF_FFFF_FFFF, 0);
    do_write(64'hA5A5_5A5A_AAAA_5555, 8);  // R3 extra bits ignored
    check("R3", cmd_data, 64'hA5A5_5A5A_AAAA_5555);

    // R4: short write
    frame_start();
    send_byte(8'h48);
    for (int i = 0; i < 40; i++) clk_bit(i[1]);
    frame_stop();
    check("R4", cmd_data, last_cmd);

    // R5: unknown control byte
    frame_start();
    send_byte(8'h55);
    for (int i = 0; i < 64; i++) begin
      clk_bit(i[0]);
      check("R5 no drive", {126'b0, sdio_oe, gpo_oe}, 128'd0);
    end
    frame_stop();
    check("R5", cmd_data, last_cmd);

    // R6 R7: shared-pin read
    do_read(1'b0, 128'h8001_2345_6789_ABCD_EF00_F0F0_3C3C_C3C1, 1'b0);
    // R8: dedicated-pin read
    do_read(1'b1, 128'h7F3E_1D0C_5A5A_0FF0_1234_8765_CAFE_0B01, 1'b0);
    // R9: response changed mid read
    do_read(1'b0, 128'hDEAD_BEEF_0001_0203_0405_0607_0809_0A0B, 1'b1);

    // R10: read cut off by enable
    rsp_data = {8{16'hF00F}};
    frame_start();
    send_byte(8'h80);
    for (int j = 0; j < 30; j++) clk_bit(1'b0);
    sen_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R10 abort", {126'b0, sdio_oe, gpo_oe}, 128'd0);
    frame_stop();

    // R2: good write after aborted frames
    do_write(64'h1357_9BDF_2468_ACE0, 0);
    check("R2", cmd_data, 64'h1357_9BDF_2468_ACE0);

    repeat (10) @(negedge clk);
    check("R3 strobes", pulses, 4);
    check("R3 queue", exp_q.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule